// File: doc/BRIEF.md
# CAN Receive Message Queue with Head Window

This block sits between a CAN receive engine and a CPU register bus. Frames that the receive engine has already accepted are pushed in on a frame-source port. Each frame carries a 32-bit identifier word, a 4-bit length code and eight data bytes. The block keeps them in a small first-in first-out store.

The CPU never addresses individual slots. It sees only the oldest pending frame, through one fixed window of byte registers. Once it has copied that frame out, it releases the slot by writing the advance code 0xFF to the pointer register. The next frame then appears in the same window.

A control byte turns the queue on and off and selects how a full queue reacts to a new frame. The same byte reports whether anything is pending. A receive status bit, gated by an enable bit, drives the interrupt line. A sticky overrun flag records every frame that met a full queue.

Top module: `can_rxfifo_window`

## Requirements
- R1: After reset the control byte (address 0x10) reads 0x80: queue off, keep-oldest mode, empty. The status byte (0x12), the enable byte (0x13) and the error byte (0x14) read 0x00, and `irq_rx` is low.
- R2: While the queue is on, frames leave in arrival order. The window shows the head frame as follows:
  - identifier byte k (bits 8k+7:8k) at address k, for k = 0 to 3;
  - the length code in bits 3:0 of address 0x05, with bits 7:4 reading 0;
  - data byte j at address 0x06+j.
- R3: Control bit 7 is a read-only empty flag, 1 exactly when no frame is pending. Control bit 0 (queue on) and bit 3 (overwrite mode) read back as written.
- R4: Writing 0xFF to address 0x11 releases the head frame. Any other value written there is ignored, and so is 0xFF while the queue is empty.
- R5: With bit 3 = 1, a frame arriving at a full queue (4 entries) replaces the newest stored frame, and error bit 5 is set.
- R6: With bit 3 = 0, a frame arriving at a full queue is dropped, the stored frames are unchanged, and error bit 5 is set.
- R7: Frames arriving while the queue is off are dropped and set neither status bit 4 nor error bit 5.
- R8: Writing the control byte with bit 0 = 0 discards every pending frame. The queue reads empty, and stays empty when it is turned on again.
- R9: Status bit 4 is set each time a frame is stored. A write to address 0x12 with bit 4 = 0 clears it. A write with bit 4 = 1 leaves it unchanged. A frame stored in the same cycle as a clear leaves the bit set.
- R10: `irq_rx` is high exactly when status bit 4 and enable bit 4 (address 0x13) are both 1.
- R11: Error bit 5 stays set until a write to address 0x14 with bit 5 = 0 clears it.
- R12: When a release and a new frame coincide on a full queue, both take effect and no overrun is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a received frame is presented |
| rx_id | input | 32 | Identifier word (bit 31 extended flag, bit 30 remote flag, ID in 28:18 or 28:0) |
| rx_dlc | input | 4 | Length code |
| rx_data | input | 64 | Data bytes, byte j in bits 8j+7:8j |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr`, combinational |
| irq_rx | output | 1 | Receive interrupt request |

## Verification
Some properties are checked by assertions on every cycle:
- the stored count never exceeds the depth;
- a frame offered while the queue is off leaves it empty, and turning the queue off empties it at once;
- a release attempt on an empty queue changes nothing;
- a frame dropped at a full queue in keep-oldest mode leaves the count unchanged and raises the overrun flag;
- every stored frame raises status bit 4;
- the interrupt stays low while its enable is clear.

Other behaviour can only be shown by the bench's scenarios, which read the head frame back through the window:
- the exact content and order of the frames;
- which frame the overwrite mode replaces;
- that release codes other than 0xFF have no effect;
- the simultaneous release-and-push case.

// File: rtl/can_rxq_pkg.sv
// Package: shared frame type, register addresses and bit positions for the
// receive queue window. Assumes a byte-wide register bus.
package can_rxq_pkg;

    localparam int ID_W    = 32;
    localparam int NBYTES  = 8;
    localparam int DLC_W   = 4;
    localparam int REG_AW  = 8;

    // Register byte addresses
    localparam logic [REG_AW-1:0] A_ID0  = 8'h00;
    localparam logic [REG_AW-1:0] A_DLC  = 8'h05;
    localparam logic [REG_AW-1:0] A_DAT0 = 8'h06;
    localparam logic [REG_AW-1:0] A_CTL  = 8'h10;
    localparam logic [REG_AW-1:0] A_PTR  = 8'h11;
    localparam logic [REG_AW-1:0] A_ISR  = 8'h12;
    localparam logic [REG_AW-1:0] A_IER  = 8'h13;
    localparam logic [REG_AW-1:0] A_ERR  = 8'h14;

    // Bit positions
    localparam int CTL_EN    = 0;
    localparam int CTL_OVW   = 3;
    localparam int CTL_EMPTY = 7;
    localparam int ISR_RX    = 4;
    localparam int ERR_OVR   = 5;

    localparam logic [7:0] PTR_ADVANCE = 8'hFF;

    typedef struct packed {
        logic [ID_W-1:0]     id;
        logic [DLC_W-1:0]    dlc;
        logic [NBYTES*8-1:0] data;
    } rx_frame_t;

endpackage

// File: rtl/rxq_store.sv
// Module: rxq_store
// Frame storage with read/write pointers and an occupancy count.
// New frames go to the tail; a full queue either drops the arriving frame
// or, in overwrite mode, replaces the newest stored frame.
// Assumes DEPTH is a power of two, and that pop is asserted only when the
// queue is non-empty.
module rxq_store
    import can_rxq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic             pop,
    input  logic             overwrite_mode,
    input  rx_frame_t        frame_in,
    output rx_frame_t        head,
    output logic [$clog2(DEPTH):0] count,
    output logic             empty,
    output logic             stored,
    output logic             overrun
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [PTR_W-1:0] wr_ptr, rd_ptr, newest;
    logic             full, room, take_new, take_over;
    rx_frame_t        mem [DEPTH];

    assign full      = (count == FULL_CNT);
    assign empty     = (count == '0);
    assign room      = !full || pop;
    assign take_new  = push && room;
    assign take_over = push && !room && overwrite_mode;
    assign overrun   = push && !room;
    assign stored    = take_new || take_over;
    assign newest    = wr_ptr - PTR_W'(1);
    assign head      = mem[rd_ptr];

    // Pointer and count update, cleared by reset or flush
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (take_new) wr_ptr <= wr_ptr + PTR_W'(1);
            if (pop)      rd_ptr <= rd_ptr + PTR_W'(1);
            count <= count + CNT_W'(take_new) - CNT_W'(pop);
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        // Slot i loads on a tail write or on an overwrite of the newest slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[i] <= '0;
            end else if ((take_new && wr_ptr == PTR_W'(i)) ||
                         (take_over && newest == PTR_W'(i))) begin
                mem[i] <= frame_in;
            end
        end
    end

endmodule

// File: rtl/rxq_ctrl.sv
// Module: rxq_ctrl
// Control, status, enable and error registers. Also decodes the release
// command. Status and error bits are sticky: an event sets them, and a
// write of 0 to the bit clears them, with the event taking priority.
module rxq_ctrl
    import can_rxq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              empty,
    input  logic              stored,
    input  logic              overrun,
    output logic              en,
    output logic              ovw_mode,
    output logic              isr_rx,
    output logic              ier_rx,
    output logic              err_ovr,
    output logic              pop,
    output logic              flush,
    output logic              irq
);

    logic ctl_wr, ptr_wr, isr_wr, ier_wr, err_wr;

    assign ctl_wr = reg_wr && (reg_addr == A_CTL);
    assign ptr_wr = reg_wr && (reg_addr == A_PTR);
    assign isr_wr = reg_wr && (reg_addr == A_ISR);
    assign ier_wr = reg_wr && (reg_addr == A_IER);
    assign err_wr = reg_wr && (reg_addr == A_ERR);

    assign pop   = ptr_wr && (reg_wdata == PTR_ADVANCE) && en && !empty;
    assign flush = ctl_wr && !reg_wdata[CTL_EN];
    assign irq   = isr_rx && ier_rx;

    // Control byte: queue on and overwrite mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en       <= 1'b0;
            ovw_mode <= 1'b0;
        end else if (ctl_wr) begin
            en       <= reg_wdata[CTL_EN];
            ovw_mode <= reg_wdata[CTL_OVW];
        end
    end

    // Interrupt enable bit
    always_ff @(posedge clk) begin
        if (!rst_n)      ier_rx <= 1'b0;
        else if (ier_wr) ier_rx <= reg_wdata[ISR_RX];
    end

    // Receive status: set on store, cleared by a zero write
    always_ff @(posedge clk) begin
        if (!rst_n) isr_rx <= 1'b0;
        else        isr_rx <= stored || (isr_rx && !(isr_wr && !reg_wdata[ISR_RX]));
    end

    // Overrun flag: set on overrun, cleared by a zero write
    always_ff @(posedge clk) begin
        if (!rst_n) err_ovr <= 1'b0;
        else        err_ovr <= overrun || (err_ovr && !(err_wr && !reg_wdata[ERR_OVR]));
    end

endmodule

// File: rtl/rxq_rdmux.sv
// Module: rxq_rdmux
// Combinational register read decode: the head-frame window plus the
// control, status, enable and error bytes. Unmapped addresses read 0.
module rxq_rdmux
    import can_rxq_pkg::*;
(
    input  logic [REG_AW-1:0] reg_addr,
    input  rx_frame_t         head,
    input  logic              en,
    input  logic              ovw_mode,
    input  logic              empty,
    input  logic              isr_rx,
    input  logic              ier_rx,
    input  logic              err_ovr,
    output logic [7:0]        reg_rdata
);

    localparam int ID_BYTES = ID_W / 8;

    // Select the byte for the addressed register
    always_comb begin
        reg_rdata = 8'h00;
        if (reg_addr < REG_AW'(ID_BYTES)) begin
            reg_rdata = head.id[int'(reg_addr)*8 +: 8];
        end else if (reg_addr == A_DLC) begin
            reg_rdata = {{(8-DLC_W){1'b0}}, head.dlc};
        end else if (reg_addr >= A_DAT0 && reg_addr < A_DAT0 + REG_AW'(NBYTES)) begin
            reg_rdata = head.data[int'(reg_addr - A_DAT0)*8 +: 8];
        end else begin
            case (reg_addr)
                A_CTL: begin
                    reg_rdata[CTL_EN]    = en;
                    reg_rdata[CTL_OVW]   = ovw_mode;
                    reg_rdata[CTL_EMPTY] = empty;
                end
                A_ISR:   reg_rdata[ISR_RX]  = isr_rx;
                A_IER:   reg_rdata[ISR_RX]  = ier_rx;
                A_ERR:   reg_rdata[ERR_OVR] = err_ovr;
                default: reg_rdata = 8'h00;
            endcase
        end
    end

endmodule

// File: rtl/can_rxfifo_window.sv
// Module: can_rxfifo_window (top)
// Receive message queue read through a single head-frame window.
// Frames from the source are accepted only while the queue is on.
// Assumes the source presents each frame for one cycle and that frames
// have already passed acceptance filtering.
module can_rxfifo_window
    import can_rxq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_valid,
    input  logic [ID_W-1:0]     rx_id,
    input  logic [DLC_W-1:0]    rx_dlc,
    input  logic [NBYTES*8-1:0] rx_data,
    input  logic                reg_wr,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [7:0]          reg_wdata,
    output logic [7:0]          reg_rdata,
    output logic                irq_rx
);

    localparam int CNT_W = $clog2(DEPTH) + 1;

    rx_frame_t        frame_in, head;
    logic [CNT_W-1:0] count;
    logic             empty, stored, overrun;
    logic             en, ovw_mode, isr_rx, ier_rx, err_ovr;
    logic             pop, flush, push;

    assign frame_in = '{id: rx_id, dlc: rx_dlc, data: rx_data};
    assign push     = rx_valid && en;

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk            (clk),
        .rst_n          (rst_n),
        .flush          (flush),
        .push           (push),
        .pop            (pop),
        .overwrite_mode (ovw_mode),
        .frame_in       (frame_in),
        .head           (head),
        .count          (count),
        .empty          (empty),
        .stored         (stored),
        .overrun        (overrun)
    );

    rxq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .empty     (empty),
        .stored    (stored),
        .overrun   (overrun),
        .en        (en),
        .ovw_mode  (ovw_mode),
        .isr_rx    (isr_rx),
        .ier_rx    (ier_rx),
        .err_ovr   (err_ovr),
        .pop       (pop),
        .flush     (flush),
        .irq       (irq_rx)
    );

    rxq_rdmux u_rdmux (
        .reg_addr  (reg_addr),
        .head      (head),
        .en        (en),
        .ovw_mode  (ovw_mode),
        .empty     (empty),
        .isr_rx    (isr_rx),
        .ier_rx    (ier_rx),
        .err_ovr   (err_ovr),
        .reg_rdata (reg_rdata)
    );

endmodule

// File: rtl/rxq_checker.sv
// Module: rxq_checker
// Cycle-by-cycle properties of the receive queue, attached to the top
// module by the bind statement at the end of this file.
module rxq_checker #(
    parameter int DEPTH = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    rx_valid,
    input logic                    en,
    input logic                    ovw_mode,
    input logic                    pop,
    input logic                    isr_rx,
    input logic                    ier_rx,
    input logic                    err_ovr,
    input logic                    irq_rx,
    input logic [$clog2(DEPTH):0]  count
);

    localparam int CNT_W = $clog2(DEPTH) + 1;

    // R5
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R7
    off_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && rx_valid && count == '0) |=> (count == '0));

    // R8
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en) |-> (count == '0));

    // R4
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && !rx_valid) |=> (count == '0));

    // R6
    keep_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !ovw_mode && rx_valid && !pop && count == CNT_W'(DEPTH))
        |=> ($stable(count) && err_ovr));

    // R9
    store_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rx_valid && count < CNT_W'(DEPTH)) |=> isr_rx);

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ier_rx |-> !irq_rx);

endmodule

bind can_rxfifo_window rxq_checker #(.DEPTH(DEPTH)) u_rxq_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .en       (en),
    .ovw_mode (ovw_mode),
    .pop      (pop),
    .isr_rx   (isr_rx),
    .ier_rx   (ier_rx),
    .err_ovr  (err_ovr),
    .irq_rx   (irq_rx),
    .count    (count)
);

// File: tb/test_can_rxfifo_window.sv
// Directed bench for can_rxfifo_window: one task per scenario.
module test_can_rxfifo_window;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [31:0] rx_id = '0;
    logic [3:0]  rx_dlc = '0;
    logic [63:0] rx_data = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        irq_rx;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    can_rxfifo_window i_can_rxfifo_window (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_id(rx_id),
        .rx_dlc(rx_dlc), .rx_data(rx_data), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_rx(irq_rx)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic push(input logic [31:0] id, input logic [3:0] dlc, input logic [63:0] data);
        @(negedge clk);
        rx_valid = 1'b1; rx_id = id; rx_dlc = dlc; rx_data = data;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    function automatic logic [63:0] pat(input logic [7:0] s);
        logic [63:0] v;
        for (int j = 0; j < 8; j++) v[j*8 +: 8] = s + 8'(j);
        return v;
    endfunction

    function automatic logic [31:0] fid(input int k);
        return 32'h8000_0000 | 32'(k * 32'h0011_1111);
    endfunction

    task automatic chk_reg(input string tag, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        chk(tag, {56'h0, d}, {56'h0, exp});
    endtask

    task automatic chk_head(input string tag, input logic [31:0] id,
                            input logic [3:0] dlc, input logic [63:0] data);
        logic [7:0]  b;
        logic [31:0] gid;
        logic [63:0] gdat;
        for (int k = 0; k < 4; k++) begin rd(8'(k), b); gid[k*8 +: 8] = b; end
        chk({tag, " id"}, {32'h0, gid}, {32'h0, id});
        rd(8'h05, b);
        chk({tag, " dlc"}, {56'h0, b}, {60'h0, dlc});
        for (int j = 0; j < 8; j++) begin rd(8'(6 + j), b); gdat[j*8 +: 8] = b; end
        chk({tag, " data"}, gdat, data);
    endtask

    task automatic restart(input logic [7:0] ctl);
        wr(8'h10, 8'h00);
        wr(8'h10, ctl);
        wr(8'h14, 8'h00);
        wr(8'h12, 8'h00);
    endtask

    task automatic t_reset;
        chk_reg("R1 ctl", 8'h10, 8'h80);
        chk_reg("R1 isr", 8'h12, 8'h00);
        chk_reg("R1 ier", 8'h13, 8'h00);
        chk_reg("R1 err", 8'h14, 8'h00);
        chk("R1 irq", {63'h0, irq_rx}, 64'h0);
    endtask

    task automatic t_order;
        restart(8'h01);
        chk_reg("R3 on empty", 8'h10, 8'h81);
        push(32'h123 << 18, 4'd8, pat(8'h10));
        push(32'h8000_0000 | 32'h1ABC_DEF, 4'd3, pat(8'h40));
        push(32'h4000_0000 | (32'h7FF << 18), 4'd0, pat(8'h70));
        chk_reg("R3 not empty", 8'h10, 8'h01);
        chk_head("R2 std", 32'h123 << 18, 4'd8, pat(8'h10));
        wr(8'h11, 8'hFF);
        chk_head("R2 ext", 32'h81AB_CDEF, 4'd3, pat(8'h40));
        wr(8'h11, 8'hFF);
        chk_head("R2 rtr", 32'h4000_0000 | (32'h7FF << 18), 4'd0, pat(8'h70));
        wr(8'h11, 8'hFF);
        chk_reg("R3 drained", 8'h10, 8'h81);
    endtask

    task automatic t_ptr;
        restart(8'h01);
        wr(8'h11, 8'hFF);
        chk_reg("R4 pop on empty", 8'h10, 8'h81);
        push(fid(1), 4'd5, pat(8'hA0));
        wr(8'h11, 8'hFE);
        chk_reg("R4 non-FF kept", 8'h10, 8'h01);
        chk_head("R4 head kept", fid(1), 4'd5, pat(8'hA0));
        wr(8'h11, 8'hFF);
        chk_reg("R4 FF releases", 8'h10, 8'h81);
    endtask

    task automatic t_irq;
        restart(8'h01);
        push(fid(2), 4'd1, pat(8'h01));
        chk_reg("R9 set on store", 8'h12, 8'h10);
        chk("R10 irq masked", {63'h0, irq_rx}, 64'h0);
        wr(8'h13, 8'h10);
        #1;
        chk("R10 irq enabled", {63'h0, irq_rx}, 64'h1);
        wr(8'h12, 8'hFF);
        chk_reg("R9 write 1 keeps", 8'h12, 8'h10);
        wr(8'h12, 8'h00);
        chk_reg("R9 write 0 clears", 8'h12, 8'h00);
        #1;
        chk("R10 irq low", {63'h0, irq_rx}, 64'h0);
        // clear and store in the same cycle: store wins
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'h12; reg_wdata = 8'h00;
        rx_valid = 1'b1; rx_id = fid(3); rx_dlc = 4'd2; rx_data = pat(8'h02);
        @(negedge clk);
        reg_wr = 1'b0; rx_valid = 1'b0;
        chk_reg("R9 store beats clear", 8'h12, 8'h10);
        wr(8'h13, 8'h00);
    endtask

    task automatic fill4;
        for (int k = 0; k < 4; k++) push(fid(10 + k), 4'(k + 1), pat(8'(16 * k)));
    endtask

    task automatic t_keep_oldest;
        restart(8'h01);
        fill4();
        push(fid(14), 4'd7, pat(8'hEE));
        chk_reg("R6 overrun flag", 8'h14, 8'h20);
        for (int k = 0; k < 4; k++) begin
            chk_head("R6 oldest kept", fid(10 + k), 4'(k + 1), pat(8'(16 * k)));
            wr(8'h11, 8'hFF);
        end
        chk_reg("R6 dropped", 8'h10, 8'h81);
        wr(8'h14, 8'h20);
        chk_reg("R11 write 1 keeps", 8'h14, 8'h20);
        wr(8'h14, 8'h00);
        chk_reg("R11 cleared", 8'h14, 8'h00);
    endtask

    task automatic t_overwrite;
        restart(8'h09);
        chk_reg("R3 mode readback", 8'h10, 8'h89);
        fill4();
        push(fid(14), 4'd7, pat(8'hEE));
        chk_reg("R5 overrun flag", 8'h14, 8'h20);
        for (int k = 0; k < 3; k++) begin
            chk_head("R5 older kept", fid(10 + k), 4'(k + 1), pat(8'(16 * k)));
            wr(8'h11, 8'hFF);
        end
        chk_head("R5 newest replaced", fid(14), 4'd7, pat(8'hEE));
        wr(8'h11, 8'hFF);
        chk_reg("R5 drained", 8'h10, 8'h89);
    endtask

    task automatic t_disabled;
        restart(8'h00);
        push(fid(20), 4'd4, pat(8'h55));
        chk_reg("R7 still empty", 8'h10, 8'h80);
        chk_reg("R7 no status", 8'h12, 8'h00);
        chk_reg("R7 no overrun", 8'h14, 8'h00);
        wr(8'h11, 8'hFF);
        wr(8'h10, 8'h01);
        chk_reg("R7 empty when on", 8'h10, 8'h81);
    endtask

    task automatic t_flush;
        restart(8'h01);
        push(fid(30), 4'd1, pat(8'h11));
        push(fid(31), 4'd2, pat(8'h22));
        wr(8'h10, 8'h00);
        chk_reg("R8 flushed", 8'h10, 8'h80);
        wr(8'h10, 8'h01);
        chk_reg("R8 empty after on", 8'h10, 8'h81);
    endtask

    task automatic t_simul;
        restart(8'h01);
        fill4();
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'h11; reg_wdata = 8'hFF;
        rx_valid = 1'b1; rx_id = fid(14); rx_dlc = 4'd9; rx_data = pat(8'hC0);
        @(negedge clk);
        reg_wr = 1'b0; rx_valid = 1'b0;
        chk_reg("R12 no overrun", 8'h14, 8'h00);
        for (int k = 1; k < 4; k++) begin
            chk_head("R12 order", fid(10 + k), 4'(k + 1), pat(8'(16 * k)));
            wr(8'h11, 8'hFF);
        end
        chk_head("R12 new frame", fid(14), 4'd9, pat(8'hC0));
        wr(8'h11, 8'hFF);
        chk_reg("R12 drained", 8'h10, 8'h81);
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_order();
        t_ptr();
        t_irq();
        t_keep_oldest();
        t_overwrite();
        t_disabled();
        t_flush();
        t_simul();
        done = 1;
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            summary();
        end
    end

endmodule